// File: doc/BRIEF.md
# Multi-Mode Acquisition Decimator

This block sits behind a sampling converter and turns a full-rate stream of signed samples into a slower stream of record points. Each point stands for one decimation interval of N = 2^k valid input samples. The mode input picks how the interval is reduced. Sample mode keeps one raw value and drops the others. Peak mode tracks the smallest and largest value of every sample. Fine-resolution mode computes a boxcar average that carries extra fraction bits. Envelope mode folds the interval extremes into a per-point store, so that repeated acquisitions widen a running min/max band.

A record-start strobe realigns interval counting and point numbering to the start of a new acquisition. A separate clear input empties the envelope store. Each finished interval is reported by a single-cycle valid pulse, together with a min/max pair and a widened average.

Top module: `acq_decimator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `pt_valid` is 0 and `pt_min`, `pt_max` and `pt_wide` are all 0.
- R2: In sample mode (`acq_mode` = 0), `pt_min` and `pt_max` both equal the first valid sample of the interval.
- R3: In peak mode (`acq_mode` = 1) and fine-resolution mode (`acq_mode` = 2), `pt_min` and `pt_max` are the signed minimum and maximum of every valid sample in the interval. A single extreme sample always appears in them, and with N = 1 both equal the sample.
- R4: In every mode, `pt_wide` equals floor(sum × 2^EXTRA / N), where sum is the signed sum of the interval's samples. With the default parameters this is a 12-bit signed value.
- R5: N = 2^`dec_log2` for `dec_log2` from 0 to 8. One point is produced per N valid samples, and cycles with `smp_valid` low have no effect.
- R6: In envelope mode (`acq_mode` = 3), each point carries the min and max of its interval merged with everything stored at its point index since the last clear. The merged pair is written back to that index. The point index rises by one per point in every mode and wraps at ENV_DEPTH.
- R7: `rec_start` discards any partial interval and sets the point index to 0. A valid sample in the same cycle is the first sample of the new interval.
- R8: `env_clear` empties the whole envelope store. An envelope point that completes in the same cycle is stored and reported with its own interval values only.
- R9: `pt_valid` is high for exactly one cycle, in the cycle after the last sample of an interval is accepted, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Input sample qualifier |
| smp_data | input | IN_W | Signed input sample |
| dec_log2 | input | DW | log2 of the decimation factor (0..LOG2_MAX) |
| acq_mode | input | 2 | 0 sample, 1 peak, 2 fine resolution, 3 envelope |
| rec_start | input | 1 | Start-of-record strobe |
| env_clear | input | 1 | Empties the envelope store |
| pt_valid | output | 1 | One-cycle point strobe |
| pt_min | output | IN_W | Signed point minimum |
| pt_max | output | IN_W | Signed point maximum |
| pt_wide | output | IN_W+EXTRA | Signed scaled interval average |

## Verification
Two functions can meet in one cycle: clearing the envelope store and completing an envelope point, and likewise a record restart and the first sample of an interval. The bench raises `env_clear` together with the last sample of a point that already holds stored history. The point must come back with only its own interval extremes, and later acquisitions must merge from that fresh value while the other indices restart empty. The bench also raises `rec_start` together with a valid sample after a partial interval made of large values. The result must show no trace of those values, and it must be written at index 0.

// File: rtl/acq_dec_pkg.sv
// Shared definitions for the acquisition decimator.
package acq_dec_pkg;
    typedef enum logic [1:0] {
        MODE_SAMPLE = 2'd0,
        MODE_PEAK   = 2'd1,
        MODE_HIRES  = 2'd2,
        MODE_ENV    = 2'd3
    } acq_mode_e;
endpackage

// File: rtl/acq_interval_accum.sv
// Interval accumulator: counts valid samples into intervals of 2^dec_log2
// and tracks the first sample, the min, the max and the sum of each one.
// It flags the cycle that accepts the last sample and presents that
// interval's results combinationally in the same cycle.
// Assumes dec_log2 holds still within an interval; larger values clamp.
module acq_interval_accum #(
    parameter int IN_W     = 8,
    parameter int LOG2_MAX = 8,
    parameter int EXTRA    = 4,
    localparam int DW      = $clog2(LOG2_MAX + 1),
    localparam int SUM_W   = IN_W + LOG2_MAX,
    localparam int WIDE_W  = IN_W + EXTRA,
    localparam int SC_W    = SUM_W + EXTRA
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [IN_W-1:0]   smp_data,
    input  logic        [DW-1:0]     dec_log2,
    input  logic                     rec_start,
    output logic                     done,
    output logic signed [IN_W-1:0]   iv_first,
    output logic signed [IN_W-1:0]   iv_min,
    output logic signed [IN_W-1:0]   iv_max,
    output logic signed [WIDE_W-1:0] iv_wide
);
    logic        [LOG2_MAX-1:0] cnt;
    logic        [LOG2_MAX-1:0] cnt_eff;
    logic        [LOG2_MAX-1:0] last_idx;
    logic        [LOG2_MAX:0]   span;
    logic        [DW-1:0]       dec_eff;
    logic                       is_first;
    logic                       is_last;
    logic signed [IN_W-1:0]     acc_first, acc_min, acc_max;
    logic signed [SUM_W-1:0]    acc_sum, nxt_sum;
    logic signed [SC_W-1:0]     scaled, shifted;

    // Clamp the factor and derive the index of the interval's last sample.
    always_comb begin
        dec_eff  = (dec_log2 > DW'(LOG2_MAX)) ? DW'(LOG2_MAX) : dec_log2;
        span     = (LOG2_MAX + 1)'(1) << dec_eff;
        last_idx = LOG2_MAX'(span - 1'b1);
        cnt_eff  = rec_start ? '0 : cnt;
        is_first = (cnt_eff == '0);
        is_last  = (cnt_eff == last_idx);
        done     = smp_valid && is_last;
    end

    // Merge the incoming sample into the running interval statistics.
    always_comb begin
        iv_first = is_first ? smp_data : acc_first;
        iv_min   = (is_first || smp_data < acc_min) ? smp_data : acc_min;
        iv_max   = (is_first || smp_data > acc_max) ? smp_data : acc_max;
        nxt_sum  = is_first ? SUM_W'(smp_data) : acc_sum + SUM_W'(smp_data);
        scaled   = SC_W'(nxt_sum) <<< EXTRA;
        shifted  = scaled >>> dec_eff;
        iv_wide  = WIDE_W'(shifted);
    end

    // Advance the sample counter and hold the partial interval state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            acc_first <= '0;
            acc_min   <= '0;
            acc_max   <= '0;
            acc_sum   <= '0;
        end else if (smp_valid) begin
            cnt       <= is_last ? '0 : cnt_eff + 1'b1;
            acc_first <= iv_first;
            acc_min   <= iv_min;
            acc_max   <= iv_max;
            acc_sum   <= nxt_sum;
        end else if (rec_start) begin
            cnt <= '0;
        end
    end

    AST_ACC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (acc_min <= acc_max)); // R3
endmodule

// File: rtl/acq_env_store.sv
// Envelope store: keeps one min/max pair per record point, with a flag per
// entry. A cleared entry behaves as if it held the extreme values. The read
// is combinational and the merged pair is written back on wr_en.
// Assumes DEPTH is a power of two.
module acq_env_store #(
    parameter int IN_W  = 8,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   clear,
    input  logic        [AW-1:0]   addr,
    input  logic signed [IN_W-1:0] iv_min,
    input  logic signed [IN_W-1:0] iv_max,
    output logic signed [IN_W-1:0] env_min,
    output logic signed [IN_W-1:0] env_max
);
    logic signed [IN_W-1:0] mem_min [DEPTH];
    logic signed [IN_W-1:0] mem_max [DEPTH];
    logic        [DEPTH-1:0] vld;
    logic                    hit;

    // Merge the stored pair, if live and not being cleared, with the interval.
    always_comb begin
        hit     = vld[addr] && !clear;
        env_min = (hit && mem_min[addr] < iv_min) ? mem_min[addr] : iv_min;
        env_max = (hit && mem_max[addr] > iv_max) ? mem_max[addr] : iv_max;
    end

    // Entry flags: a clear empties all of them, and a write sets its own.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (clear) vld <= '0;
            if (wr_en) vld[addr] <= 1'b1;
        end
    end

    // Pair storage, written back on every envelope point.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_min[addr] <= env_min;
            mem_max[addr] <= env_max;
        end
    end

    AST_ENV_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (env_min <= iv_min) && (env_max >= iv_max)); // R6
endmodule

// File: rtl/acq_decimator.sv
// Multi-mode acquisition decimator top level. It reduces each interval of
// 2^dec_log2 valid samples to one point: raw sample, peak pair, fine
// resolution average, or cross-acquisition envelope. The point index is
// numbered here and the registered point stream is driven from here.
// Assumes ENV_DEPTH is a power of two and WIDE_W holds the scaled input.
module acq_decimator
    import acq_dec_pkg::*;
#(
    parameter int IN_W      = 8,
    parameter int LOG2_MAX  = 8,
    parameter int EXTRA     = 4,
    parameter int ENV_DEPTH = 1024,
    localparam int DW       = $clog2(LOG2_MAX + 1),
    localparam int AW       = $clog2(ENV_DEPTH),
    localparam int WIDE_W   = IN_W + EXTRA
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [IN_W-1:0]   smp_data,
    input  logic        [DW-1:0]     dec_log2,
    input  logic        [1:0]        acq_mode,
    input  logic                     rec_start,
    input  logic                     env_clear,
    output logic                     pt_valid,
    output logic signed [IN_W-1:0]   pt_min,
    output logic signed [IN_W-1:0]   pt_max,
    output logic signed [WIDE_W-1:0] pt_wide
);
    acq_mode_e              mode, out_mode;
    logic                   done;
    logic signed [IN_W-1:0] iv_first, iv_min, iv_max, env_min, env_max;
    logic signed [WIDE_W-1:0] iv_wide;
    logic [AW-1:0]          pt_idx, idx_eff;
    logic                   env_wr;

    // Decode the mode and the point index used by this cycle.
    always_comb begin
        mode    = acq_mode_e'(acq_mode);
        idx_eff = rec_start ? '0 : pt_idx;
        env_wr  = done && (mode == MODE_ENV);
    end

    acq_interval_accum #(
        .IN_W(IN_W), .LOG2_MAX(LOG2_MAX), .EXTRA(EXTRA)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .dec_log2(dec_log2), .rec_start(rec_start), .done(done),
        .iv_first(iv_first), .iv_min(iv_min), .iv_max(iv_max),
        .iv_wide(iv_wide)
    );

    acq_env_store #(
        .IN_W(IN_W), .DEPTH(ENV_DEPTH)
    ) u_env (
        .clk(clk), .rst_n(rst_n), .wr_en(env_wr), .clear(env_clear),
        .addr(idx_eff), .iv_min(iv_min), .iv_max(iv_max),
        .env_min(env_min), .env_max(env_max)
    );

    // Step the point index once per point; a record start rewinds it.
    always_ff @(posedge clk) begin
        if (!rst_n)         pt_idx <= '0;
        else if (done)      pt_idx <= idx_eff + 1'b1;
        else if (rec_start) pt_idx <= '0;
    end

    // Register the point chosen by the mode and pulse the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_valid <= 1'b0;
            pt_min   <= '0;
            pt_max   <= '0;
            pt_wide  <= '0;
            out_mode <= MODE_SAMPLE;
        end else begin
            pt_valid <= done;
            if (done) begin
                out_mode <= mode;
                pt_wide  <= iv_wide;
                case (mode)
                    MODE_SAMPLE: begin pt_min <= iv_first; pt_max <= iv_first; end
                    MODE_ENV:    begin pt_min <= env_min;  pt_max <= env_max;  end
                    default:     begin pt_min <= iv_min;   pt_max <= iv_max;   end
                endcase
            end
        end
    end

    logic signed [WIDE_W-1:0] min_sc, max_sc;
    assign min_sc = WIDE_W'(pt_min) <<< EXTRA;
    assign max_sc = WIDE_W'(pt_max) <<< EXTRA;

    AST_PT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> (pt_min <= pt_max)); // R3
    AST_SAMPLE_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && out_mode == MODE_SAMPLE) |-> (pt_min == pt_max)); // R2
    AST_WIDE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && (out_mode == MODE_PEAK || out_mode == MODE_HIRES))
        |-> (pt_wide >= min_sc) && (pt_wide <= max_sc)); // R4
    AST_PT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> $past(smp_valid)); // R9
endmodule

// File: tb/acq_decimator_bench.sv
`timescale 1ns/1ps
module acq_decimator_bench;
    localparam int IN_W = 8, LOG2_MAX = 8, EXTRA = 4, DEPTH = 8;
    localparam int WIDE_W = IN_W + EXTRA;

    logic clk = 1'b0, rst_n = 1'b0;
    logic smp_valid = 1'b0, rec_start = 1'b0, env_clear = 1'b0;
    logic signed [IN_W-1:0] smp_data = '0;
    logic [3:0] dec_log2 = '0;
    logic [1:0] acq_mode = '0;
    logic pt_valid;
    logic signed [IN_W-1:0] pt_min, pt_max;
    logic signed [WIDE_W-1:0] pt_wide;

    always #2.5 clk = ~clk;

    acq_decimator #(.IN_W(IN_W), .LOG2_MAX(LOG2_MAX), .EXTRA(EXTRA),
                    .ENV_DEPTH(DEPTH)) u_acq_decimator (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .dec_log2(dec_log2), .acq_mode(acq_mode), .rec_start(rec_start),
        .env_clear(env_clear), .pt_valid(pt_valid), .pt_min(pt_min),
        .pt_max(pt_max), .pt_wide(pt_wide));

    int n_run = 0, n_fail = 0, idx = 0;
    int em_min [DEPTH];
    int em_max [DEPTH];
    bit ev [DEPTH];
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gen(input int seed, input int i);
        return ((seed * 37 + i * 53 + i * i * 11) % 256) - 128;
    endfunction

    // One interval: drive N samples, optional gaps, then check the point.
    task automatic run_pt(input int md, input int dl, input int seed, input bit gaps,
                          input bit rs, input bit ec, input bit glitch);
        int n, f, mn, mx, sm, s, emn, emx, ew;
        bit early;
        string tag;
        n = 1 << dl; early = 0; sm = 0; f = 0; mn = 0; mx = 0;
        if (rs) idx = 0;
        for (int i = 0; i < n; i++) begin
            s = gen(seed, i);
            if (glitch && i == (seed % n)) s = (seed % 2 == 1) ? 127 : -128;
            if (i == 0) begin f = s; mn = s; mx = s; end
            if (s < mn) mn = s;
            if (s > mx) mx = s;
            sm += s;
            @(negedge clk);
            if (pt_valid) early = 1;
            acq_mode = 2'(md); dec_log2 = 4'(dl);
            smp_valid = 1; smp_data = 8'(s);
            rec_start = rs && (i == 0);
            env_clear = ec && (i == n - 1);
            if (gaps && i < n - 1) begin
                @(negedge clk);
                if (pt_valid) early = 1;
                smp_valid = 0; smp_data = 8'(-s - 1); rec_start = 0; env_clear = 0; // R5 gap
            end
        end
        @(negedge clk);
        smp_valid = 0; rec_start = 0; env_clear = 0;
        if (ec) for (int k = 0; k < DEPTH; k++) ev[k] = 0;
        case (md)
            0: begin emn = f; emx = f; tag = "R2"; end
            3: begin
                emn = mn; emx = mx; tag = ec ? "R8" : "R6";
                if (ev[idx]) begin
                    if (em_min[idx] < emn) emn = em_min[idx];
                    if (em_max[idx] > emx) emx = em_max[idx];
                end
                ev[idx] = 1; em_min[idx] = emn; em_max[idx] = emx;
            end
            default: begin emn = mn; emx = mx; tag = "R3"; end
        endcase
        ew = (sm * 16) >>> dl;
        chk(!early, "R9", "valid inside interval", int'(early), 0);
        chk(pt_valid == 1'b1, "R9", "valid after last sample", int'(pt_valid), 1);
        chk(int'(pt_min) == emn, tag, "pt_min", int'(pt_min), emn);
        chk(int'(pt_max) == emx, tag, "pt_max", int'(pt_max), emx);
        chk(int'(pt_wide) == ew, "R4", "pt_wide", int'(pt_wide), ew);
        idx = (idx + 1) % DEPTH;
    endtask

    // Feed k large samples and stop mid-interval, optionally with a bare restart.
    task automatic partial(input int k, input bit bare_rs);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            smp_valid = 1; smp_data = 8'sd127; acq_mode = 2'd3; dec_log2 = 4'd3;
        end
        @(negedge clk);
        smp_valid = 0; rec_start = bare_rs;
        @(negedge clk);
        chk(pt_valid == 1'b0, "R7", "no point from partial", int'(pt_valid), 0);
        rec_start = 0;
        if (bare_rs) idx = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) begin ev[k] = 0; em_min[k] = 0; em_max[k] = 0; end
        repeat (4) @(negedge clk);
        chk(pt_valid == 0 && pt_min == 0 && pt_max == 0 && pt_wide == 0, "R1",
            "outputs in reset", int'(pt_wide), 0);
        rst_n = 1;
        @(negedge clk);
        chk(pt_valid == 0 && pt_min == 0 && pt_max == 0 && pt_wide == 0, "R1",
            "outputs after reset", int'(pt_valid), 0);
        // R2 R3 R4 R5: every factor in the three non-envelope modes
        for (int md = 0; md < 3; md++)
            for (int dl = 0; dl <= LOG2_MAX; dl++)
                run_pt(md, dl, md * 20 + dl + 1, dl % 3 == 1, 0, 0, md == 1);
        // R6: four acquisitions folding into the envelope
        for (int acq = 0; acq < 4; acq++)
            for (int p = 0; p < DEPTH; p++)
                run_pt(3, 2, acq * 50 + p * 7 + 3, p % 2 == 1, p == 0, 0, 1);
        // R8: clear coincides with completion of point 3 of a new acquisition
        for (int p = 0; p < DEPTH; p++)
            run_pt(3, 1, 400 + p * 13, 0, p == 0, p == 3, 0);
        // R6: index wraps past DEPTH without a restart
        for (int p = 0; p < DEPTH + 3; p++)
            run_pt(3, 0, 600 + p * 5, 0, 0, 0, 0);
        // R7: restart with a valid sample after a partial interval
        partial(5, 0);
        run_pt(1, 3, 91, 0, 1, 0, 0);
        run_pt(3, 3, 92, 0, 0, 0, 0);
        // R7: bare restart after a partial interval, then envelope at index 0
        partial(3, 1);
        run_pt(3, 3, 93, 1, 0, 0, 0);
        run_pt(2, 2, 94, 0, 0, 0, 0);
        @(negedge clk);
        chk(pt_valid == 1'b0, "R9", "valid drops", int'(pt_valid), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule